// File: doc/BRIEF.md
# MII Management Serial Master

This block is a bit-serial master for the management interface of an Ethernet PHY. It reads and writes 16-bit registers in the PHY. A host presents a command and pulses `start_i`. The command has four fields: the direction, a 5-bit PHY address, a 5-bit register number and, for a write, 16 bits of data. The block then produces a complete management frame. It drives the management clock, the serial data output and the output enable, and it samples the serial data input.

Each frame has a fixed length and ends with one trailing idle clock. A read frame is 64 clocks long and uses a single turnaround period. A write frame is 65 clocks long and uses two turnaround periods. A run-time divider sets the length of each clock half-period in system cycles. Read data appears on `rdata_o` in the same cycle as a one-cycle `done_o` pulse and stays there until the next read completes.

Top module: `mdio_master`

## Requirements
- R1: After synchronous reset, `mdc_o`, `mdo_o`, `oe_o`, `busy_o` and `done_o` are 0 and `rdata_o` is 0.
- R2: Every frame opens with 32 clock periods in which `oe_o`=1 and `mdo_o`=1 (bit periods 0..31).
- R3: Bit periods 32 and 33 carry 0 then 1. Bit periods 34 and 35 carry 1,0 when `op_i`=0 (read) and 0,1 when `op_i`=1 (write). All four are driven with `oe_o`=1.
- R4: Bit periods 36..40 carry `phy_i[4:0]` and bit periods 41..45 carry `reg_i[4:0]`, each most significant bit first, with `oe_o`=1.
- R5: A write frame has 65 clock periods. Periods 46 and 47 have `oe_o`=0. Periods 48..63 carry `wdata_i[15:0]`, MSB first, with `oe_o`=1. Period 64 has `oe_o`=0. Whenever `oe_o`=0, `mdo_o` is 0.
- R6: A read frame has 64 clock periods. Periods 46..63 all have `oe_o`=0: one turnaround period, 16 input periods and one final period.
- R7: Each bit period starts with `mdc_o` low and then has `mdc_o` high. Each phase lasts `half_i` system cycles, and `half_i`=0 acts as 1. The value of `half_i` is captured at start.
- R8: `mdi_i` is sampled at the last system cycle of each high phase. The values taken in periods 47..62 form `rdata_o`, with period 47 as bit 15. `rdata_o` changes only in the cycle of `done_o` that ends a read frame. A write frame leaves it unchanged.
- R9: Between frames, `mdc_o`, `mdo_o` and `oe_o` are all 0.
- R10: `busy_o` rises in the cycle after an accepted start and stays high until the frame ends. `busy_o` falls in the cycle that `done_o` pulses for one cycle. A start request while `busy_o`=1 is ignored: it does not alter the frame in progress and does not begin another frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a frame (accepted only when idle) |
| op_i | input | 1 | 0 = read, 1 = write |
| phy_i | input | 5 | PHY address |
| reg_i | input | 5 | Register number |
| wdata_i | input | 16 | Write data |
| half_i | input | DIVW | Clock half-period in system cycles (0 acts as 1) |
| mdi_i | input | 1 | Serial data from the PHY |
| mdc_o | output | 1 | Management clock |
| mdo_o | output | 1 | Serial data to the PHY |
| oe_o | output | 1 | Output enable for the data line |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| rdata_o | output | 16 | Last read result |

## Verification
The assertions check rules that hold in every cycle:
- the line stays quiet while idle, and `mdo_o` stays low whenever the output is released;
- `done_o` is a single-cycle pulse that coincides with the fall of `busy_o`;
- a frame never ends without `done_o`;
- `rdata_o` holds its value outside a done cycle.

Other behaviour can only be shown by the bench scenarios, which watch the serial line as a PHY would. These include the bit order and length of each frame and the turnaround periods, which differ between reads and writes. They also include the measured phase length, including `half_i`=0, the assembly of the read value from PHY-driven bits, and a start request made mid-frame having no effect.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int IDXW     = 7;
    localparam int PRE_LEN  = 32;
    localparam int RD_LAST  = 63;
    localparam int WR_LAST  = 64;
    localparam int RD_FIRST_IN = 47;
    localparam int RD_LAST_IN  = 62;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } mdio_op_e;

    typedef struct packed {
        mdio_op_e    op;
        logic [4:0]  phy;
        logic [4:0]  regn;
        logic [15:0] wdata;
    } mdio_cmd_t;

    typedef struct packed {
        logic drive;
        logic val;
    } mdio_bit_t;

    typedef struct packed {
        logic            busy;
        logic            phase;   // 0 = clock low, 1 = clock high
        logic [IDXW-1:0] idx;
    } mdio_seq_t;

    // Index of the last bit period of a frame for a given direction
    function automatic logic [IDXW-1:0] last_idx(mdio_op_e op);
        return (op == OP_WRITE) ? IDXW'(WR_LAST) : IDXW'(RD_LAST);
    endfunction

    // True for the bit periods whose sampled input forms the read word
    function automatic logic in_rd_window(logic [IDXW-1:0] idx);
        return (int'(idx) >= RD_FIRST_IN) && (int'(idx) <= RD_LAST_IN);
    endfunction

    // Output drive and level for one bit period of the frame
    function automatic mdio_bit_t frame_bit(mdio_cmd_t c, logic [IDXW-1:0] idx);
        mdio_bit_t b;
        int i;
        i       = int'(idx);
        b.drive = 1'b1;
        b.val   = 1'b0;
        if (i < PRE_LEN)                 b.val = 1'b1;
        else if (i == 32)                b.val = 1'b0;
        else if (i == 33)                b.val = 1'b1;
        else if (i == 34)                b.val = (c.op == OP_READ);
        else if (i == 35)                b.val = (c.op == OP_WRITE);
        else if (i <= 40)                b.val = c.phy[3'(40 - i)];
        else if (i <= 45)                b.val = c.regn[3'(45 - i)];
        else if (c.op == OP_WRITE && i >= 48 && i <= 63)
                                         b.val = c.wdata[4'(63 - i)];
        else                             b.drive = 1'b0;
        return b;
    endfunction

endpackage

// File: rtl/mdio_halfper.sv
module mdio_halfper #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [DIVW-1:0] half_i,
    output logic            tick_o
);
    logic [DIVW-1:0] cnt_q;
    logic [DIVW-1:0] lim;

    assign lim    = (half_i == '0) ? '0 : half_i - 1'b1;
    assign tick_o = run && (cnt_q == lim);

    always_ff @(posedge clk) begin
        if (rst || !run || tick_o) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/mdio_capture.sv
module mdio_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (en) q <= {q[W-2:0], din};
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start_i,
    input  logic            op_i,
    input  logic [4:0]      phy_i,
    input  logic [4:0]      reg_i,
    input  logic [15:0]     wdata_i,
    input  logic [DIVW-1:0] half_i,
    input  logic            mdi_i,
    output logic            mdc_o,
    output logic            mdo_o,
    output logic            oe_o,
    output logic            busy_o,
    output logic            done_o,
    output logic [15:0]     rdata_o
);
    mdio_seq_t       st;
    mdio_cmd_t       cmd;
    logic [DIVW-1:0] half_q;
    logic            tick;
    logic            cap_en;
    logic [15:0]     shift_q;
    mdio_bit_t       cur;

    mdio_halfper #(.DIVW(DIVW)) u_div (
        .clk    (clk),
        .rst    (rst),
        .run    (st.busy),
        .half_i (half_q),
        .tick_o (tick)
    );

    assign cap_en = st.busy && st.phase && tick &&
                    (cmd.op == OP_READ) && in_rd_window(st.idx);

    mdio_capture #(.W(16)) u_cap (
        .clk (clk),
        .rst (rst),
        .en  (cap_en),
        .din (mdi_i),
        .q   (shift_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= '0;
            cmd     <= '0;
            half_q  <= '0;
            done_o  <= 1'b0;
            rdata_o <= '0;
        end else begin
            done_o <= 1'b0;
            if (!st.busy) begin
                if (start_i) begin
                    st.busy   <= 1'b1;
                    st.phase  <= 1'b0;
                    st.idx    <= '0;
                    cmd.op    <= mdio_op_e'(op_i);
                    cmd.phy   <= phy_i;
                    cmd.regn  <= reg_i;
                    cmd.wdata <= wdata_i;
                    half_q    <= half_i;
                end
            end else if (tick) begin
                if (!st.phase) begin
                    st.phase <= 1'b1;
                end else if (st.idx == last_idx(cmd.op)) begin
                    st.busy  <= 1'b0;
                    st.phase <= 1'b0;
                    done_o   <= 1'b1;
                    if (cmd.op == OP_READ) rdata_o <= shift_q;
                end else begin
                    st.idx   <= st.idx + 1'b1;
                    st.phase <= 1'b0;
                end
            end
        end
    end

    assign cur    = frame_bit(cmd, st.idx);
    assign busy_o = st.busy;
    assign mdc_o  = st.busy && st.phase;
    assign oe_o   = st.busy && cur.drive;
    assign mdo_o  = st.busy && cur.drive && cur.val;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
    input logic        clk,
    input logic        rst,
    input logic        start_i,
    input logic        mdc_o,
    input logic        mdo_o,
    input logic        oe_o,
    input logic        busy_o,
    input logic        done_o,
    input logic [15:0] rdata_o
);
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_busy_fall_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    assert_no_restart_R10: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> (busy_o || done_o));

    assert_idle_lines_R9: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!mdc_o && !mdo_o && !oe_o));

    assert_released_low_R5: assert property (@(posedge clk) disable iff (rst)
        !oe_o |-> !mdo_o);

    assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(rdata_o));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .mdc_o   (mdc_o),
    .mdo_o   (mdo_o),
    .oe_o    (oe_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .rdata_o (rdata_o)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
    localparam int DIVW = 8;
    localparam int NV   = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start_i = 1'b0;
    logic            op_i = 1'b0;
    logic [4:0]      phy_i = '0;
    logic [4:0]      reg_i = '0;
    logic [15:0]     wdata_i = '0;
    logic [DIVW-1:0] half_i = 8'd1;
    logic            mdi_i = 1'b1;
    logic            mdc_o, mdo_o, oe_o, busy_o, done_o;
    logic [15:0]     rdata_o;

    always #4 clk = ~clk;   // 125 MHz

    mdio_master #(.DIVW(DIVW)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
        .phy_i(phy_i), .reg_i(reg_i), .wdata_i(wdata_i), .half_i(half_i),
        .mdi_i(mdi_i), .mdc_o(mdc_o), .mdo_o(mdo_o), .oe_o(oe_o),
        .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o)
    );

    // {op, phy, reg, data (write data or PHY read value), half}
    localparam logic [34:0] VEC [NV] = '{
        {1'b0, 5'h01, 5'h02, 16'hA5C3, 8'd2},
        {1'b1, 5'h1F, 5'h00, 16'h8001, 8'd1},
        {1'b0, 5'h10, 5'h1F, 16'hFFFF, 8'd3},
        {1'b1, 5'h0A, 5'h15, 16'h1234, 8'd4},
        {1'b0, 5'h00, 5'h00, 16'h0001, 8'd0},
        {1'b0, 5'h15, 5'h0A, 16'h0000, 8'd2}
    };

    int n_chk = 0;
    int n_bad = 0;

    // PHY-side monitor state
    logic        prev_mdc = 1'b0;
    int          nrise = 0;
    int          run_len = 0;
    int          exp_half = 1;
    int          phase_bad = 0;
    int          ndone = 0;
    logic [15:0] phy_val = '0;
    logic        cap_mdo [0:79];
    logic        cap_oe  [0:79];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_oe(input logic op, input int i);
        if (i < 46) return 1'b1;
        if (op && i >= 48 && i <= 63) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic exp_mdo(input logic op, input logic [4:0] ph,
                                     input logic [4:0] rg, input logic [15:0] d,
                                     input int i);
        if (i < 32) return 1'b1;
        if (i == 32) return 1'b0;
        if (i == 33) return 1'b1;
        if (i == 34) return ~op;
        if (i == 35) return op;
        if (i >= 36 && i <= 40) return ph[40 - i];
        if (i >= 41 && i <= 45) return rg[45 - i];
        if (op && i >= 48 && i <= 63) return d[63 - i];
        return 1'b0;
    endfunction

    // PHY model: records the line at each rising clock, drives data after each fall
    initial begin
        forever begin
            @(negedge clk);
            if (done_o) ndone++;
            if (busy_o || prev_mdc) begin
                if (mdc_o == prev_mdc) begin
                    run_len++;
                end else begin
                    if (run_len != exp_half) phase_bad++;
                    run_len = 1;
                    if (mdc_o) begin
                        if (nrise < 80) begin
                            cap_mdo[nrise] = mdo_o;
                            cap_oe[nrise]  = oe_o;
                        end
                        nrise++;
                    end else begin
                        if (nrise >= 47 && nrise <= 62) mdi_i = phy_val[62 - nrise];
                        else                           mdi_i = 1'b1;
                    end
                end
                prev_mdc = mdc_o;
            end
        end
    end

    task automatic arm_monitor(input logic [DIVW-1:0] h, input logic [15:0] pv);
        nrise     = 0;
        run_len   = 0;
        phase_bad = 0;
        ndone     = 0;
        prev_mdc  = 1'b0;
        exp_half  = (h == 0) ? 1 : int'(h);
        phy_val   = pv;
        mdi_i     = 1'b1;
    endtask

    task automatic wait_done(output bit ok);
        int t;
        ok = 1'b0;
        for (t = 0; t < 20000; t++) begin
            @(negedge clk);
            if (done_o) begin ok = 1'b1; break; end
        end
    endtask

    task automatic pulse_start(input logic op, input logic [4:0] ph, input logic [4:0] rg,
                               input logic [15:0] d, input logic [DIVW-1:0] h);
        op_i = op; phy_i = ph; reg_i = rg; wdata_i = d; half_i = h;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic check_frame(input logic op, input logic [4:0] ph, input logic [4:0] rg,
                               input logic [15:0] d, input string tag);
        int len, mm_pre, mm_hdr, mm_tail, mm_oe;
        len = op ? 65 : 64;
        mm_pre = 0; mm_hdr = 0; mm_tail = 0; mm_oe = 0;
        for (int i = 0; i < len && i < 80; i++) begin
            if (cap_oe[i] !== exp_oe(op, i)) mm_oe++;
            if (cap_mdo[i] !== exp_mdo(op, ph, rg, d, i)) begin
                if (i < 32)      mm_pre++;
                else if (i < 46) mm_hdr++;
                else             mm_tail++;
            end
        end
        chk(nrise == len, op ? {tag, " R5 frame length"} : {tag, " R6 frame length"},
            64'(nrise), 64'(len));
        chk(mm_pre == 0, {tag, " R2 preamble bits"}, 64'(mm_pre), 64'd0);
        chk(mm_hdr == 0, {tag, " R3 R4 start/op/address bits"}, 64'(mm_hdr), 64'd0);
        chk(mm_tail == 0, {tag, " R5 data/turnaround bits"}, 64'(mm_tail), 64'd0);
        chk(mm_oe == 0, op ? {tag, " R5 output enable pattern"}
                           : {tag, " R6 output enable pattern"}, 64'(mm_oe), 64'd0);
        chk(phase_bad == 0, {tag, " R7 phase length"}, 64'(phase_bad), 64'd0);
    endtask

    initial begin
        #1600000;
        n_chk++; n_bad++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        bit ok;
        logic [15:0] last_rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({mdc_o, mdo_o, oe_o, busy_o, done_o} == 5'b0, "R1 reset outputs",
            64'({mdc_o, mdo_o, oe_o, busy_o, done_o}), 64'd0);
        chk(rdata_o == 16'h0, "R1 reset rdata", 64'(rdata_o), 64'd0);
        last_rd = 16'h0;

        // Vector table
        for (int v = 0; v < NV; v++) begin
            logic        op;
            logic [4:0]  ph, rg;
            logic [15:0] d;
            logic [7:0]  h;
            {op, ph, rg, d, h} = VEC[v];
            arm_monitor(h, d);
            pulse_start(op, ph, rg, d, h);
            chk(busy_o == 1'b1, "R10 busy after start", 64'(busy_o), 64'd1);
            wait_done(ok);
            chk(ok, "R10 done arrives", 64'(ok), 64'd1);
            if (!ok) break;
            chk(!busy_o, "R10 busy falls with done", 64'(busy_o), 64'd0);
            @(negedge clk);
            check_frame(op, ph, rg, d, $sformatf("vec%0d", v));
            chk(ndone == 1, "R10 single done pulse", 64'(ndone), 64'd1);
            chk({mdc_o, mdo_o, oe_o} == 3'b0, "R9 idle lines after frame",
                64'({mdc_o, mdo_o, oe_o}), 64'd0);
            if (!op) last_rd = d;
            chk(rdata_o == last_rd, op ? "R8 write leaves rdata" : "R8 read data",
                64'(rdata_o), 64'(last_rd));
        end

        // Start while busy is ignored
        arm_monitor(8'd1, 16'h5A5A);
        pulse_start(1'b0, 5'h03, 5'h07, 16'h0, 8'd1);
        repeat (40) @(negedge clk);
        pulse_start(1'b1, 5'h1C, 5'h18, 16'hFFFF, 8'd3);
        wait_done(ok);
        chk(ok, "R10 done after ignored start", 64'(ok), 64'd1);
        repeat (20) @(negedge clk);
        check_frame(1'b0, 5'h03, 5'h07, 16'h0, "busy_start");
        chk(busy_o == 1'b0 && ndone == 1, "R10 ignored start launches nothing",
            64'({busy_o, 8'(ndone)}), 64'd1);
        chk(rdata_o == 16'h5A5A, "R8 read after ignored start", 64'(rdata_o), 64'h5A5A);

        // Divider sampled at start: changing half_i mid-frame has no effect
        arm_monitor(8'd2, 16'hC001);
        pulse_start(1'b0, 5'h11, 5'h0F, 16'h0, 8'd2);
        half_i = 8'd5;
        wait_done(ok);
        @(negedge clk);
        check_frame(1'b0, 5'h11, 5'h0F, 16'h0, "half_latch");
        chk(rdata_o == 16'hC001, "R8 R7 read with latched divider", 64'(rdata_o), 64'hC001);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule